// File: doc/BRIEF.md
# Legacy Memory Attribute Region Decoder

This block sits between the processor-side address path and the memory and expansion-bus paths. It classifies every physical access that falls in the legacy window from 0xA0000 to 0xFFFFF. Each access goes either to system DRAM or to the expansion bus. The decision comes from a set of programmable attribute fields and a system-management RAM control byte. Both are loaded through a byte-wide configuration write port at fixed configuration offsets. The decode is combinational on the access inputs: a new address, direction or SMM level is reflected in the same cycle. Configuration writes take effect from the cycle after the write is clocked in.

The window is divided into three kinds of region, each decoded from the 64KB block number in address bits [19:16]:

- **Top region (0xF0000–0xFFFFF).** It is governed by a single 2-bit attribute.
- **Expansion region (0xC0000–0xEFFFF).** It is cut into twelve 16KB segments. Each segment owns one nibble of a packed attribute byte.
- **Low 128KB (0xA0000–0xBFFFF).** It is hidden DRAM. It is exposed only when the control byte opens it, or when the processor is in SMM and the enable bit is set.

A read-only attribute lets reads hit DRAM. Writes under a read-only attribute are sent to the bus instead, and the block raises a write-block flag.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset every address in 0xA0000–0xFFFFF selects the bus (sel_dram=0, wr_block=0), whatever the SMM input. The attribute bytes reset to 0x00 and the SMRAM control byte resets to 0x02.
- R2: Addresses 0xF0000–0xFFFFF take their attribute from bits [5:4] of the byte written at offset 0x59.
- R3: Segment i (0..11) covers 0xC0000+0x4000·i to 0xC3FFF+0x4000·i. Its attribute comes from the byte at offset 0x5A+i/2: bits [1:0] for even i and bits [5:4] for odd i. Bits [3:2] and [7:6] of these bytes have no effect.
- R4: Attribute value 3 sends both reads and writes to DRAM with wr_block=0.
- R5: Attribute value 1 sends reads to DRAM. Writes go to the bus with wr_block=1. wr_block is never set for a read.
- R6: Attribute values 0 and 2 send all accesses to the bus with wr_block=0.
- R7: Addresses 0xA0000–0xBFFFF select DRAM (reads and writes, wr_block=0) when bit 6 of the byte at offset 0x72 is set, or when its bit 3 is set and smm_active is high. Otherwise they select the bus. No other bit of that byte has any effect.
- R8: A configuration write affects the decode from the next cycle onward. A change of smm_active affects it in the same cycle.
- R9: Addresses below 0xA0000, or with any bit above bit 19 set, select DRAM with wr_block=0.
- R10: Configuration writes to offsets other than 0x59–0x5F and 0x72 change no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | Processor is in system-management mode |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration offset of the write |
| cfg_wdata | input | 8 | Configuration byte written |
| sel_dram | output | 1 | 1 routes the access to DRAM, 0 to the expansion bus |
| wr_block | output | 1 | Write refused by a read-only DRAM attribute |

## Verification
The bench builds the decoder with ADDR_W=24. This keeps a few address bits above the 1MB boundary, so out-of-window aliasing through the upper bits (R9) is exercised. The attribute bytes are reloaded 64 times with pseudo-random values, including junk in the unused nibble bits. After each reload the first and last address of all thirteen regions are probed for reads and writes. Over the run every attribute value therefore reaches every segment and the nibble packing is covered. The SMRAM control byte is swept through all 256 values against both SMM levels. Writes are also made to offsets that neighbour the decoded ones.

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_wdata,
  output logic              sel_dram,
  output logic              wr_block
);
  localparam int NSEG      = 12;
  localparam logic [7:0] OFF_TOP  = 8'h59;
  localparam logic [7:0] OFF_SEG0 = 8'h5A;
  localparam logic [7:0] OFF_SMR  = 8'h72;
  localparam logic [7:0] SMR_RST  = 8'h02;

  logic [1:0] top_q;
  logic [1:0] seg_q [NSEG];
  logic       open_q, en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) top_q <= 2'd0;
    else if (cfg_we && cfg_off == OFF_TOP) top_q <= cfg_wdata[5:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      open_q <= SMR_RST[6];
      en_q   <= SMR_RST[3];
    end else if (cfg_we && cfg_off == OFF_SMR) begin
      open_q <= cfg_wdata[6];
      en_q   <= cfg_wdata[3];
    end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [7:0] OFF = OFF_SEG0 + 8'(i / 2);
    localparam int LSB = (i % 2) * 4;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seg_q[i] <= 2'd0;
      else if (cfg_we && cfg_off == OFF) seg_q[i] <= cfg_wdata[LSB +: 2];
  end

  wire [3:0] blk       = acc_addr[19:16];
  wire       hi_zero   = (acc_addr[ADDR_W-1:20] == '0);
  wire       in_win    = hi_zero && (blk >= 4'hA);
  wire       in_smram  = in_win && (blk < 4'hC);
  wire       in_top    = in_win && (blk == 4'hF);
  wire [3:0] seg_idx   = {blk[1:0], acc_addr[15:14]};
  wire       smram_hit = open_q | (en_q & smm_active);
  wire       unused_bits = ^{cfg_wdata[7:6], cfg_wdata[3:2], acc_addr[13:0]};

  logic [1:0] attr;
  always_comb begin
    attr = 2'd0;
    if (in_top) attr = top_q;
    else if (seg_idx < 4'(NSEG)) attr = seg_q[seg_idx];
  end

  always_comb begin
    sel_dram = 1'b1;
    wr_block = 1'b0;
    if (in_smram) begin
      sel_dram = smram_hit;
    end else if (in_win) begin
      case (attr)
        2'd3:    sel_dram = 1'b1;
        2'd1:    begin sel_dram = !acc_write; wr_block = acc_write; end
        default: sel_dram = 1'b0;
      endcase
    end
  end

  assert_outside_dram_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_addr[ADDR_W-1:20] == '0 && acc_addr[19:17] >= 3'b101) |-> (sel_dram && !wr_block));

  assert_block_only_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |-> (acc_write && !sel_dram));

  assert_smram_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:20] == '0 && acc_addr[19:17] == 3'b101 && !open_q && !(en_q && smm_active))
      |-> !sel_dram);

  assert_cfg_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(cfg_off >= OFF_TOP && cfg_off <= 8'h5F) && cfg_off != OFF_SMR)
      |=> ($stable(top_q) && $stable(open_q) && $stable(en_q)));

  assert_top_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == OFF_TOP) |=> (top_q == $past(cfg_wdata[5:4])));
endmodule

// File: tb/tb_legacy_mem_decoder.sv
module tb_legacy_mem_decoder;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_write = 0, smm_active = 0, cfg_we = 0;
  logic [7:0] cfg_off = 0, cfg_wdata = 0;
  logic sel_dram, wr_block;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] sh [7];
  logic [7:0] sh_smr;
  logic [31:0] seed = 32'h1234_5678;

  legacy_mem_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_write(acc_write),
    .smm_active(smm_active), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .sel_dram(sel_dram), .wr_block(wr_block));

  always #4 clk = ~clk;

  function automatic logic [1:0] model(input logic [AW-1:0] a, input logic w, input logic s);
    int seg;
    logic [1:0] at;
    if ((a >> 20) != 0 || a[19:0] < 20'hA0000) return 2'b10;
    if (a[19:0] < 20'hC0000)
      return {(sh_smr[6] || (sh_smr[3] && s)), 1'b0};
    if (a[19:0] >= 20'hF0000) at = sh[0][5:4];
    else begin
      seg = int'((a[19:0] - 20'hC0000) / 20'h4000);
      at = (seg % 2 == 1) ? sh[1 + seg / 2][5:4] : sh[1 + seg / 2][1:0];
    end
    case (at)
      2'd3: return 2'b10;
      2'd1: return w ? 2'b01 : 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic probe(input logic [AW-1:0] a, input logic w, input logic s, input string req);
    logic [1:0] exp;
    @(negedge clk);
    acc_addr = a; acc_write = w; smm_active = s;
    #1;
    exp = model(a, w, s);
    checks++;
    if ({sel_dram, wr_block} !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d smm=%0d got sel_dram/wr_block=%b expected=%b",
               req, a, w, s, {sel_dram, wr_block}, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (off >= 8'h59 && off <= 8'h5F) sh[off - 8'h59] = d;
    if (off == 8'h72) sh_smr = d;
  endtask

  task automatic sweep_regions(input string req);
    for (int r = 0; r < 13; r++) begin
      logic [AW-1:0] base;
      base = (r == 12) ? 24'h0F0000 : AW'(32'hC0000 + 32'h4000 * r);
      for (int w = 0; w < 2; w++) begin
        probe(base, w[0], 1'b0, req);
        probe(base + ((r == 12) ? 24'hFFFF : 24'h3FFF), w[0], 1'b1, req);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) sh[i] = 8'h00;
    sh_smr = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, window forwards to bus, SMRAM closed in and out of SMM
    sweep_regions("R1");
    probe(24'h0A0000, 1'b0, 1'b1, "R1");
    probe(24'h0BFFFF, 1'b1, 1'b0, "R1");
    // R9: outside window and upper-bit aliasing
    probe(24'h000000, 1'b1, 1'b0, "R9");
    probe(24'h09FFFF, 1'b0, 1'b1, "R9");
    probe(24'h1F0000, 1'b1, 1'b0, "R9");
    probe(24'h8C4000, 1'b0, 1'b0, "R9");
    probe(24'hFFFFFF, 1'b1, 1'b1, "R9");
    // R2 R3 R4 R5 R6: random attribute loads including junk bits
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 7; j++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        cfg_write(8'h59 + 8'(j), seed[23:16]);
      end
      sweep_regions("R3");
    end
    // R4 R5 R6 directed: all segments same attribute
    for (int v = 0; v < 4; v++) begin
      for (int j = 0; j < 7; j++) cfg_write(8'h59 + 8'(j), {2'b00, 2'(v), 2'b11 ^ 2'(v), 2'(v)});
      sweep_regions(v == 3 ? "R4" : (v == 1 ? "R5" : "R6"));
    end
    // R10: neighbouring offsets do not disturb decode
    cfg_write(8'h5A, 8'h13);
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'h00);
    cfg_write(8'h71, 8'h48);
    cfg_write(8'h73, 8'h48);
    sh_smr = 8'h02;
    probe(24'h0C0000, 1'b1, 1'b0, "R10");
    probe(24'h0C4000, 1'b0, 1'b0, "R10");
    probe(24'h0A0000, 1'b0, 1'b1, "R10");
    probe(24'h0F0000, 1'b0, 1'b0, "R10");
    // R8: config write takes effect next cycle
    cfg_write(8'h5A, 8'h03);
    probe(24'h0C1000, 1'b1, 1'b0, "R8");
    // R7: full SMRAM byte sweep against both SMM levels
    for (int b = 0; b < 256; b++) begin
      cfg_write(8'h72, 8'(b));
      for (int s = 0; s < 2; s++) begin
        probe(24'h0A0000, 1'b1, s[0], "R7");
        probe(24'h0BFFFF, 1'b0, s[0], "R7");
      end
    end
    // R8: SMM toggle acts in same cycle
    cfg_write(8'h72, 8'h08);
    probe(24'h0B0000, 1'b0, 1'b1, "R8");
    probe(24'h0B0000, 1'b0, 1'b0, "R8");
    probe(24'h0B0000, 1'b1, 1'b1, "R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule